// File: doc/BRIEF.md
# One-Time-Programmable Memory Burn Sequencer

This block is a synchronous controller that writes a complete image into a byte-wide one-time-programmable memory through its parallel pins. It drives the address, the write data and its enable, the active-low chip select, read enable and program strobe lines. It also raises two request flags for the external analog circuits: one asks for the high programming voltage and one asks for the raised supply level used while programming. Image bytes come from a simple request/acknowledge port that is indexed by address.

Each address is fetched and then burned with one program pulse at a time. After every pulse the byte is read back. The controller pulses again only when the read-back does not match, and stops at a fixed pulse limit. When every address has been handled, both requests are dropped and the whole array is read back once more and compared against the image. Every wait is a cycle count derived from a clock-frequency parameter. The first failing address and the number of pulses spent on it are reported.

Top module: `otp_burn_sequencer`

## Requirements
- R1: After reset and while idle, memCeN, memOeN and memPgmN are 1, and vppReq, vccHiReq, memDriveEn, dataReq, busy and done are 0.
- R2: While memPgmN is 0, vppReq and vccHiReq are 1, memCeN is 0, memOeN is 1, memDriveEn is 1 and memWrData equals the image byte for memAddr.
- R3: Every program pulse (memPgmN low) lasts exactly PULSE_US x CLK_MHZ cycles, where PULSE_US is 20, or 100 when LONG_PULSE is 1. This always lies inside the 20 to 105 us window.
- R4: memAddr, memWrData, memCeN, memOeN, memDriveEn, vppReq and vccHiReq are unchanged for at least 2 x CLK_MHZ cycles before memPgmN falls. memWrData stays driven and unchanged for at least 2 x CLK_MHZ cycles after memPgmN rises.
- R5: After each pulse, one read-back is made with memOeN=0, memCeN=0, memPgmN=1 and both voltage requests still at 1. A further pulse at the same address is issued only if the read byte differs from the image byte.
- R6: An address that does not verify after MAX_PULSES pulses is failed. A requested 1 over a stored 0 can never verify. The first failure sets failAddr to that address and failPulses to MAX_PULSES, and passOk ends at 0.
- R7: Image bytes are requested in address order from 0 to the last address, once per phase. dataReq is held with dataAddr stable until dataAck.
- R8: After the last address, vccHiReq and vppReq fall. Every address is then read once with memCeN=0 and memOeN=0 and compared. A mismatch there, if no earlier failure was recorded, sets failAddr to that address and failPulses to 0.
- R9: On completion, busy is 0 and done is 1, and done holds until the next start. passOk is 1 exactly when no address failed.
- R10: memDriveEn is never 1 while memOeN is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a full burn run (taken when idle) |
| dataReq | output | 1 | Image byte request |
| dataAddr | output | ADDR_W | Address of the requested image byte |
| dataAck | input | 1 | Image byte valid on dataByte |
| dataByte | input | DATA_W | Image byte |
| memAddr | output | ADDR_W | Memory address pins |
| memWrData | output | DATA_W | Data driven to memory |
| memDriveEn | output | 1 | Write data driver enable |
| memRdData | input | DATA_W | Data read from memory |
| memCeN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Read enable, active low |
| memPgmN | output | 1 | Program strobe, active low |
| vppReq | output | 1 | Request for high programming voltage |
| vccHiReq | output | 1 | Request for raised supply level |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| passOk | output | 1 | Run finished with no failed address |
| failAddr | output | ADDR_W | First failing address |
| failPulses | output | clog2(MAX_PULSES+1) | Pulses spent at first failure (0 if found in final pass) |

## Verification
The assertions assume that the memory side answers combinationally and is quiet when not read. They also assume that dataAck comes only in answer to a pending dataReq and lasts one cycle, and that start arrives only while idle. The bench keeps to these assumptions. Its memory model returns data only while chip select and read enable are both low, and it acknowledges each request for exactly one cycle. It raises start only after done. Per-address pulse needs, pre-zeroed bytes and a bit corrupted after programming drive the retry, limit and final-pass paths.

// File: rtl/otp_burn_pkg.sv
package otp_burn_pkg;

  typedef enum logic [1:0] {
    T_SETUP,
    T_PULSE,
    T_HOLD,
    T_READ
  } timerSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      timerLoad;
    timerSel_e timerSel;
    logic      addrClr;
    logic      addrInc;
    logic      pulseClr;
    logic      pulseInc;
    logic      byteLoad;
    logic      failRecProg;
    logic      failRecFinal;
    logic      runStart;
    logic      doneSet;
  } ctlStrobes_t;

  typedef struct packed {
    logic timerZero;
    logic addrLast;
    logic match;
    logic pulseMax;
  } dpStatus_t;

endpackage

// File: rtl/otp_burn_datapath.sv
module otp_burn_datapath
  import otp_burn_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int MAX_PULSES = 25,
  parameter int SETUP_CYC  = 250,
  parameter int PULSE_CYC  = 2500,
  parameter int HOLD_CYC   = 250,
  parameter int READ_CYC   = 19,
  localparam int PC_W      = $clog2(MAX_PULSES + 1),
  localparam int TMR_W     = $clog2(PULSE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [DATA_W-1:0] dataByte,
  input  logic [DATA_W-1:0] memRdData,
  output dpStatus_t         stat,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wrByte,
  output logic [ADDR_W-1:0] failAddr,
  output logic [PC_W-1:0]   failPulses,
  output logic              doneFlag,
  output logic              failed
);

  logic [TMR_W-1:0] timer;
  logic [TMR_W-1:0] timerInit;
  logic [PC_W-1:0]  pulseCnt;

  always_comb begin
    case (stb.timerSel)
      T_SETUP: timerInit = TMR_W'(SETUP_CYC - 1);
      T_PULSE: timerInit = TMR_W'(PULSE_CYC - 1);
      T_HOLD:  timerInit = TMR_W'(HOLD_CYC - 1);
      default: timerInit = TMR_W'(READ_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer      <= '0;
      addr       <= '0;
      pulseCnt   <= '0;
      wrByte     <= '1;
      failAddr   <= '0;
      failPulses <= '0;
      doneFlag   <= 1'b0;
      failed     <= 1'b0;
    end else begin
      if (stb.timerLoad)     timer <= timerInit;
      else if (timer != '0)  timer <= timer - 1'b1;
      if (stb.addrClr)       addr <= '0;
      else if (stb.addrInc)  addr <= addr + 1'b1;
      if (stb.pulseClr)      pulseCnt <= '0;
      else if (stb.pulseInc) pulseCnt <= pulseCnt + 1'b1;
      if (stb.byteLoad)      wrByte <= dataByte;
      if (stb.runStart) begin
        failed     <= 1'b0;
        failAddr   <= '0;
        failPulses <= '0;
        doneFlag   <= 1'b0;
      end else begin
        if ((stb.failRecProg || stb.failRecFinal) && !failed) begin
          failed     <= 1'b1;
          failAddr   <= addr;
          failPulses <= stb.failRecProg ? pulseCnt : '0;
        end
        if (stb.doneSet) doneFlag <= 1'b1;
      end
    end
  end

  assign stat.timerZero = (timer == '0);
  assign stat.addrLast  = (addr == '1);
  assign stat.match     = (memRdData == wrByte);
  assign stat.pulseMax  = (pulseCnt == PC_W'(MAX_PULSES));

endmodule

// File: rtl/otp_burn_control.sv
module otp_burn_control
  import otp_burn_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        dataAck,
  input  dpStatus_t   stat,
  output ctlStrobes_t stb,
  output logic        dataReq,
  output logic        memCeN,
  output logic        memOeN,
  output logic        memPgmN,
  output logic        memDriveEn,
  output logic        vppReq,
  output logic        vccHiReq,
  output logic        busy
);

  typedef enum logic [3:0] {
    S_IDLE, S_RAMP, S_FETCH, S_SETUP, S_PULSE, S_HOLD, S_VREAD,
    S_DROP, S_RFETCH, S_RREAD, S_FIN
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    stb.timerSel = T_SETUP;
    case (state)
      S_IDLE: if (start) begin
        stb.runStart  = 1'b1;
        stb.addrClr   = 1'b1;
        stb.timerLoad = 1'b1;
        stateNext     = S_RAMP;
      end
      S_RAMP: if (stat.timerZero) stateNext = S_FETCH;
      S_FETCH: begin
        stb.pulseClr = 1'b1;
        if (dataAck) begin
          stb.byteLoad  = 1'b1;
          stb.timerLoad = 1'b1;
          stateNext     = S_SETUP;
        end
      end
      S_SETUP: if (stat.timerZero) begin
        stb.timerLoad = 1'b1;
        stb.timerSel  = T_PULSE;
        stateNext     = S_PULSE;
      end
      S_PULSE: if (stat.timerZero) begin
        stb.pulseInc  = 1'b1;
        stb.timerLoad = 1'b1;
        stb.timerSel  = T_HOLD;
        stateNext     = S_HOLD;
      end
      S_HOLD: if (stat.timerZero) begin
        stb.timerLoad = 1'b1;
        stb.timerSel  = T_READ;
        stateNext     = S_VREAD;
      end
      S_VREAD: if (stat.timerZero) begin
        if (stat.match || stat.pulseMax) begin
          stb.failRecProg = !stat.match;
          if (stat.addrLast) begin
            stb.timerLoad = 1'b1;
            stateNext     = S_DROP;
          end else begin
            stb.addrInc = 1'b1;
            stateNext   = S_FETCH;
          end
        end else begin
          stb.timerLoad = 1'b1;
          stateNext     = S_SETUP;
        end
      end
      S_DROP: if (stat.timerZero) begin
        stb.addrClr = 1'b1;
        stateNext   = S_RFETCH;
      end
      S_RFETCH: if (dataAck) begin
        stb.byteLoad  = 1'b1;
        stb.timerLoad = 1'b1;
        stb.timerSel  = T_READ;
        stateNext     = S_RREAD;
      end
      S_RREAD: if (stat.timerZero) begin
        stb.failRecFinal = !stat.match;
        if (stat.addrLast) stateNext = S_FIN;
        else begin
          stb.addrInc = 1'b1;
          stateNext   = S_RFETCH;
        end
      end
      S_FIN: begin
        stb.doneSet = 1'b1;
        stateNext   = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    busy       = (state != S_IDLE);
    dataReq    = (state == S_FETCH) || (state == S_RFETCH);
    vccHiReq   = (state inside {S_RAMP, S_FETCH, S_SETUP, S_PULSE, S_HOLD, S_VREAD});
    vppReq     = vccHiReq;
    memCeN     = !(state inside {S_SETUP, S_PULSE, S_HOLD, S_VREAD, S_RREAD});
    memOeN     = !(state inside {S_VREAD, S_RREAD});
    memPgmN    = (state != S_PULSE);
    memDriveEn = (state inside {S_SETUP, S_PULSE, S_HOLD});
  end

endmodule

// File: rtl/otp_burn_sequencer.sv
module otp_burn_sequencer
  import otp_burn_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int CLK_MHZ    = 125,
  parameter bit LONG_PULSE = 1'b0,
  parameter int MAX_PULSES = 25
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               start,
  output logic                               dataReq,
  output logic [ADDR_W-1:0]                  dataAddr,
  input  logic                               dataAck,
  input  logic [DATA_W-1:0]                  dataByte,
  output logic [ADDR_W-1:0]                  memAddr,
  output logic [DATA_W-1:0]                  memWrData,
  output logic                               memDriveEn,
  input  logic [DATA_W-1:0]                  memRdData,
  output logic                               memCeN,
  output logic                               memOeN,
  output logic                               memPgmN,
  output logic                               vppReq,
  output logic                               vccHiReq,
  output logic                               busy,
  output logic                               done,
  output logic                               passOk,
  output logic [ADDR_W-1:0]                  failAddr,
  output logic [$clog2(MAX_PULSES+1)-1:0]    failPulses
);

  localparam int PULSE_US  = LONG_PULSE ? 100 : 20;
  localparam int SETUP_CYC = 2 * CLK_MHZ;
  localparam int HOLD_CYC  = 2 * CLK_MHZ;
  localparam int PULSE_CYC = PULSE_US * CLK_MHZ;
  localparam int READ_CYC  = (150 * CLK_MHZ + 999) / 1000;

  ctlStrobes_t       stb;
  dpStatus_t         stat;
  logic [ADDR_W-1:0] addr;
  logic              failed;

  otp_burn_control u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .dataAck(dataAck), .stat(stat),
    .stb(stb), .dataReq(dataReq), .memCeN(memCeN), .memOeN(memOeN),
    .memPgmN(memPgmN), .memDriveEn(memDriveEn), .vppReq(vppReq),
    .vccHiReq(vccHiReq), .busy(busy)
  );

  otp_burn_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_PULSES(MAX_PULSES),
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC),
    .READ_CYC(READ_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dataByte(dataByte),
    .memRdData(memRdData), .stat(stat), .addr(addr), .wrByte(memWrData),
    .failAddr(failAddr), .failPulses(failPulses), .doneFlag(done),
    .failed(failed)
  );

  assign dataAddr = addr;
  assign memAddr  = addr;
  assign passOk   = done && !failed;

endmodule

// File: rtl/otp_burn_checker.sv
module otp_burn_checker #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int CLK_MHZ    = 125,
  parameter int MAX_PULSES = 25
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            dataReq,
  input logic                            dataAck,
  input logic [ADDR_W-1:0]               dataAddr,
  input logic [ADDR_W-1:0]               memAddr,
  input logic [DATA_W-1:0]               memWrData,
  input logic                            memDriveEn,
  input logic                            memCeN,
  input logic                            memOeN,
  input logic                            memPgmN,
  input logic                            vppReq,
  input logic                            vccHiReq,
  input logic                            busy,
  input logic                            done,
  input logic [$clog2(MAX_PULSES+1)-1:0] failPulses
);

  localparam int PMIN      = 20 * CLK_MHZ;
  localparam int PMAX      = 105 * CLK_MHZ;
  localparam int SETUP_MIN = 2 * CLK_MHZ;
  localparam int VEC_W     = ADDR_W + DATA_W + 5;

  logic [VEC_W-1:0] pinVec, pinVecPrev;
  int               lowCnt;
  int               stableCyc;
  logic             pgmPrevLow;

  assign pinVec = {memAddr, memWrData, memCeN, memOeN, memDriveEn, vppReq, vccHiReq};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt     <= 0;
      stableCyc  <= 0;
      pgmPrevLow <= 1'b0;
      pinVecPrev <= '0;
    end else begin
      pgmPrevLow <= !memPgmN;
      pinVecPrev <= pinVec;
      lowCnt     <= memPgmN ? 0 : lowCnt + 1;
      if (pinVec != pinVecPrev) stableCyc <= 1;
      else if (stableCyc < SETUP_MIN + 1) stableCyc <= stableCyc + 1;
    end
  end

  p_pulse_cond_r2: assert property (@(posedge clk) disable iff (!rstN)
    !memPgmN |-> vppReq && vccHiReq && !memCeN && memOeN && memDriveEn);

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memPgmN && pgmPrevLow) |-> (lowCnt >= PMIN) && (lowCnt <= PMAX));

  p_setup_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!memPgmN && !pgmPrevLow) |-> stableCyc >= SETUP_MIN);

  p_stable_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!memPgmN && pgmPrevLow) |-> $stable(memWrData) && $stable(memAddr));

  p_verify_safe_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN && vccHiReq) |-> vppReq && memPgmN && !memCeN);

  p_fail_limit_r6: assert property (@(posedge clk) disable iff (!rstN)
    failPulses <= MAX_PULSES);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dataReq && !dataAck) |=> dataReq && $stable(dataAddr));

  p_final_supply_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN && !vccHiReq) |-> !vppReq && !memCeN && busy);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_no_contention_r10: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDriveEn);

endmodule

bind otp_burn_sequencer otp_burn_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_MHZ(CLK_MHZ), .MAX_PULSES(MAX_PULSES)
) u_chk (
  .clk(clk), .rstN(rstN), .dataReq(dataReq), .dataAck(dataAck),
  .dataAddr(dataAddr), .memAddr(memAddr), .memWrData(memWrData),
  .memDriveEn(memDriveEn), .memCeN(memCeN), .memOeN(memOeN),
  .memPgmN(memPgmN), .vppReq(vppReq), .vccHiReq(vccHiReq), .busy(busy),
  .done(done), .failPulses(failPulses)
);

// File: tb/tb_otp_burn_sequencer.sv
`timescale 1ns/1ps
module tb_otp_burn_sequencer;

  localparam int AW    = 3;
  localparam int NADDR = 1 << AW;
  localparam int MAXP  = 4;
  localparam int PW    = 20;
  localparam int SETUP = 2;
  localparam int HOLD  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic dataAck = 1'b0;
  logic [7:0] dataByte = '0;
  logic dataReq, memDriveEn, memCeN, memOeN, memPgmN, vppReq, vccHiReq;
  logic busy, done, passOk;
  logic [AW-1:0] dataAddr, memAddr, failAddr;
  logic [2:0] failPulses;
  logic [7:0] memWrData, memRdData;

  logic [7:0] srcMem [NADDR];
  logic [7:0] memArr [NADDR];
  logic [7:0] preArr [NADDR];
  int need [NADDR];
  int pulsesAt [NADDR];

  int errors = 0, checks = 0;
  int violPulse, violWidth, violSetup, violHold, violCont, violVer, violSeq;
  int progReads, finalReads, reqIdx;
  bit corruptEn;

  always #4 clk = ~clk;

  assign memRdData = (!memCeN && !memOeN) ? memArr[memAddr] : 8'h00;

  otp_burn_sequencer #(.ADDR_W(AW), .DATA_W(8), .CLK_MHZ(1), .LONG_PULSE(1'b0),
                       .MAX_PULSES(MAXP)) dut (
    .clk(clk), .rstN(rstN), .start(start), .dataReq(dataReq), .dataAddr(dataAddr),
    .dataAck(dataAck), .dataByte(dataByte), .memAddr(memAddr), .memWrData(memWrData),
    .memDriveEn(memDriveEn), .memRdData(memRdData), .memCeN(memCeN), .memOeN(memOeN),
    .memPgmN(memPgmN), .vppReq(vppReq), .vccHiReq(vccHiReq), .busy(busy), .done(done),
    .passOk(passOk), .failAddr(failAddr), .failPulses(failPulses)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // image source: one-cycle acknowledge after each request
  always @(negedge clk) begin
    if (dataAck) dataAck = 1'b0;
    else if (dataReq) begin
      dataByte = srcMem[dataAddr];
      dataAck  = 1'b1;
    end
  end

  // behavioural memory and pin-timing reference, sampled every clock
  logic [AW+8+4:0] vecPrev;
  int  stableCnt = 0, pulseLen = 0, holdCnt = 0;
  bit  holdActive = 0;
  logic [7:0] pulseData;
  logic prevPgm = 1, prevOe = 1, prevReq = 0, prevVcc = 0;

  always @(negedge clk) begin
    logic [AW+8+4:0] vec;
    vec = {memAddr, memWrData, memCeN, memOeN, memDriveEn, vppReq, vccHiReq};
    if (vec == vecPrev) stableCnt++; else stableCnt = 1;
    vecPrev = vec;
    if (!memPgmN) begin
      // R2 pin state during a pulse
      if (!(vppReq && vccHiReq && !memCeN && memOeN && memDriveEn &&
            memWrData == srcMem[memAddr])) violPulse++;
      if (prevPgm) begin
        if (stableCnt - 1 < SETUP) violSetup++;
        pulseData = memWrData;
        pulseLen  = 1;
      end else pulseLen++;
    end else if (!prevPgm) begin
      if (pulseLen != PW) violWidth++;
      pulsesAt[memAddr]++;
      if (pulsesAt[memAddr] >= need[memAddr]) memArr[memAddr] &= pulseData;
      holdActive = 1;
      holdCnt    = 0;
    end
    if (holdActive) begin
      if (memDriveEn && memWrData == pulseData) holdCnt++;
      else begin
        if (holdCnt < HOLD) violHold++;
        holdActive = 0;
      end
    end
    if (!memOeN && memDriveEn) violCont++;
    if (!memOeN && prevOe) begin
      if (vccHiReq) begin
        if (!(vppReq && !memCeN && memPgmN)) violVer++;
        progReads++;
      end else begin
        if (vppReq || memCeN) violVer++;
        finalReads++;
      end
    end
    if (dataReq && !prevReq) begin
      if (int'(dataAddr) != reqIdx % NADDR) violSeq++;
      reqIdx++;
    end
    if (corruptEn && prevVcc && !vccHiReq) memArr[NADDR-1] &= 8'hFE;
    prevPgm = memPgmN;
    prevOe  = memOeN;
    prevReq = dataReq;
    prevVcc = vccHiReq;
  end

  task automatic runScen(input string name, input bit corrupt);
    int  expP [NADDR];
    bit  expPass = 1;
    int  expFA = 0, expFP = 0, totP = 0, cyc = 0;
    for (int a = 0; a < NADDR; a++) begin
      bit ok;
      ok = ((preArr[a] & srcMem[a]) == srcMem[a]) && (need[a] <= MAXP);
      expP[a] = ok ? need[a] : MAXP;
      totP += expP[a];
      if (!ok && expPass) begin expPass = 0; expFA = a; expFP = MAXP; end
    end
    if (corrupt && expPass) begin expPass = 0; expFA = NADDR - 1; expFP = 0; end
    @(negedge clk);
    for (int a = 0; a < NADDR; a++) begin memArr[a] = preArr[a]; pulsesAt[a] = 0; end
    violPulse = 0; violWidth = 0; violSetup = 0; violHold = 0; violCont = 0;
    violVer = 0; violSeq = 0; progReads = 0; finalReads = 0; reqIdx = 0;
    corruptEn = corrupt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    check(cyc < 20000, "R9", {name, " finished before watchdog"}, cyc, 20000);
    check(done && !busy, "R9", {name, " done high busy low"}, {done, busy}, 2);
    check(passOk == expPass, "R9", {name, " passOk"}, passOk, expPass);
    if (!expPass) begin
      check(int'(failAddr) == expFA, "R6", {name, " failAddr"}, failAddr, expFA);
      check(int'(failPulses) == expFP, corrupt ? "R8" : "R6", {name, " failPulses"},
            failPulses, expFP);
    end
    for (int a = 0; a < NADDR; a++)
      check(pulsesAt[a] == expP[a], "R5", $sformatf("%s pulses at %0d", name, a),
            pulsesAt[a], expP[a]);
    check(progReads == totP, "R5", {name, " one read-back per pulse"}, progReads, totP);
    check(finalReads == NADDR, "R8", {name, " final pass reads"}, finalReads, NADDR);
    check(violPulse == 0, "R2", {name, " pulse pin state"}, violPulse, 0);
    check(violWidth == 0, "R3", {name, " pulse width"}, violWidth, 0);
    check(violSetup == 0, "R4", {name, " setup before pulse"}, violSetup, 0);
    check(violHold == 0, "R4", {name, " data hold after pulse"}, violHold, 0);
    check(violVer == 0, "R5", {name, " read-back pin state"}, violVer, 0);
    check(violSeq == 0 && reqIdx == 2 * NADDR, "R7", {name, " request order"},
          reqIdx, 2 * NADDR);
    check(violCont == 0, "R10", {name, " no drive during read"}, violCont, 0);
    repeat (5) @(negedge clk);
    check(done && !busy, "R9", {name, " done held while idle"}, done, 1);
  endtask

  initial begin
    for (int a = 0; a < NADDR; a++) begin
      srcMem[a] = 8'(8'h5B ^ (a * 37)) | 8'h01;
      preArr[a] = 8'hFF;
      need[a]   = 1;
    end
    repeat (3) @(negedge clk);
    // R1 idle pin state in reset and after release
    check(memCeN && memOeN && memPgmN && !vppReq && !vccHiReq && !memDriveEn &&
          !dataReq && !busy && !done, "R1", "idle in reset", 0, 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(memCeN && memOeN && memPgmN && !vppReq && !vccHiReq && !memDriveEn &&
          !dataReq && !busy && !done, "R1", "idle after reset", 0, 1);

    runScen("single-pulse", 1'b0);

    need[0] = 1; need[1] = 3; need[2] = 2; need[3] = 4;
    need[4] = 1; need[5] = 2; need[6] = 3; need[7] = 1;
    runScen("retry", 1'b0);

    need[5] = 9; need[6] = 7;
    runScen("limit", 1'b0);

    for (int a = 0; a < NADDR; a++) need[a] = 1;
    preArr[2] = 8'h0F; srcMem[2] = 8'h3C; preArr[6] = 8'h00; srcMem[6] = 8'h81;
    runScen("one-over-zero", 1'b0);

    preArr[2] = 8'hFF; preArr[6] = 8'hFF;
    runScen("final-mismatch", 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL R9 watchdog expired: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule